// File: doc/BRIEF.md
# Floating-Point Result Rounder

This block is the last stage of a floating-point datapath. It receives a result that the arithmetic upstream has already normalized. The result arrives as a sign, a biased exponent and a significand with its hidden leading one. Alongside it come two extra low-order bits: a round bit and a sticky bit. From these the block forms the final stored fraction and exponent under one of four selectable rounding directions.

The decision to add one unit in the last place depends on three things: the selected direction, the sign of the result and the two extra bits. If the addition ripples out of an all-ones fraction, the significand is renormalized to 1.000…0 and the exponent goes up by one. Two flags travel with the result. One reports that precision was lost. The other reports that rounding pushed the exponent into the reserved all-ones code.

All outputs are registered. A result presented before a rising clock edge appears on the outputs after that edge.

Top module: `fp_round_unit`

## Requirements
- R1: With mode code 2'b00 (nearest, ties to even), round/sticky = 00 or 01 leaves the significand unchanged, and round/sticky = 11 adds one to the last fraction bit.
- R2: With mode 2'b00 and round/sticky = 10, the significand is incremented only when fraction bit 0 is 1. Otherwise it is left unchanged.
- R3: With mode 2'b10 (toward plus infinity), the significand is incremented when the sign is 0 and the round or sticky bit is 1. It is left unchanged in every other case.
- R4: With mode 2'b11 (toward minus infinity), the significand is incremented when the sign is 1 and the round or sticky bit is 1. It is left unchanged in every other case.
- R5: With mode 2'b01 (toward zero), the fraction and exponent always pass through unchanged.
- R6: An increment applied to an all-ones fraction yields an all-zero fraction and an exponent one greater than the input exponent. Without such a carry, the exponent passes through unchanged.
- R7: The inexact flag equals the OR of the round and sticky bits in every mode.
- R8: The overflow flag is 1 exactly when a rounding carry raises the exponent from 254 to 255 (or beyond). It is 0 otherwise.
- R9: The outputs are registered with one cycle of latency. While reset is asserted, all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the result (1 = negative) |
| exp_i | input | EXP_W (8) | Biased exponent of the normalized result |
| sig_i | input | FRAC_W+1 (24) | Significand; bit FRAC_W is the hidden one, bits FRAC_W-1:0 the fraction |
| rnd_i | input | 1 | Round bit, just below the last fraction bit |
| stk_i | input | 1 | Sticky bit, OR of all lower discarded bits |
| mode_i | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| frac_o | output | FRAC_W (23) | Rounded stored fraction |
| exp_o | output | EXP_W (8) | Exponent after any renormalization |
| inexact_o | output | 1 | Round or sticky bit was set |
| ovf_o | output | 1 | Rounding carried the exponent into the all-ones code |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. With these widths the exponent value 254 and the all-ones fraction are concrete codes. The random stimulus steers toward them often, so the renormalizing carry and the overflow edge come up many times, not almost never. Directed cases pin down each mode under both signs and the nearest-even tie with both parities of the last bit.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } round_mode_e;

endpackage

// File: rtl/fp_round_decide.sv
module fp_round_decide
    import fp_round_pkg::*;
(
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic       rnd_i,
    input  logic       stk_i,
    input  logic [1:0] mode_i,
    output logic       inc_o,
    output logic       inexact_o
);

    round_mode_e mode;
    logic        lost;

    always_comb begin
        mode      = round_mode_e'(mode_i);
        lost      = rnd_i | stk_i;
        inexact_o = lost;
        unique case (mode)
            RM_NEAR_EVEN: inc_o = rnd_i & (stk_i | lsb_i);
            RM_TO_ZERO:   inc_o = 1'b0;
            RM_TO_POS:    inc_o = lost & ~sign_i;
            RM_TO_NEG:    inc_o = lost & sign_i;
            default:      inc_o = 1'b0;
        endcase
    end

    // R1 R2 R3 R4: no increment is ever made when nothing was discarded
    always_comb begin
        exact_no_inc_chk: assert (!(inc_o && !(rnd_i || stk_i)));
    end

endmodule

// File: rtl/fp_round_incr.sv
module fp_round_incr #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W:0]   sig_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic              inc_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              ovf_o
);

    localparam int SUM_W = FRAC_W + 2;
    localparam logic [EXP_W-1:0] EXP_TOP = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_EDGE = EXP_TOP - 1'b1;

    logic [SUM_W-1:0] sum;
    logic             carry;

    always_comb begin
        sum   = {1'b0, sig_i} + {{(SUM_W-1){1'b0}}, inc_i};
        carry = sum[SUM_W-1];
        if (carry) begin
            frac_o = sum[FRAC_W:1];
        end else begin
            frac_o = sum[FRAC_W-1:0];
        end
        exp_o = exp_i + {{(EXP_W-1){1'b0}}, carry};
        ovf_o = carry && (exp_i >= EXP_EDGE);
    end

    // R6: a carry out of the significand always leaves a zero fraction
    always_comb begin
        carry_zero_frac_chk: assert (!carry || frac_o == '0);
    end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
    import fp_round_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W:0]   sig_i,
    input  logic              rnd_i,
    input  logic              stk_i,
    input  logic [1:0]        mode_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              inexact_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic [EXP_W-1:0]  expo;
        logic              inexact;
        logic              ovf;
    } round_state_t;

    round_state_t st_d, st_q;

    logic              inc_w;
    logic              inexact_w;
    logic [FRAC_W-1:0] frac_w;
    logic [EXP_W-1:0]  exp_w;
    logic              ovf_w;

    fp_round_decide u_decide (
        .sign_i    (sign_i),
        .lsb_i     (sig_i[0]),
        .rnd_i     (rnd_i),
        .stk_i     (stk_i),
        .mode_i    (mode_i),
        .inc_o     (inc_w),
        .inexact_o (inexact_w)
    );

    fp_round_incr #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_incr (
        .sig_i  (sig_i),
        .exp_i  (exp_i),
        .inc_i  (inc_w),
        .frac_o (frac_w),
        .exp_o  (exp_w),
        .ovf_o  (ovf_w)
    );

    always_comb begin
        st_d.frac    = frac_w;
        st_d.expo    = exp_w;
        st_d.inexact = inexact_w;
        st_d.ovf     = ovf_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frac_o    = st_q.frac;
    assign exp_o     = st_q.expo;
    assign inexact_o = st_q.inexact;
    assign ovf_o     = st_q.ovf;

    // R5
    to_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == RM_TO_ZERO) |=> (frac_o == $past(sig_i[FRAC_W-1:0]) && exp_o == $past(exp_i)));

    // R7
    exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rnd_i && !stk_i) |=> (!inexact_o && frac_o == $past(sig_i[FRAC_W-1:0]) && !ovf_o));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> inexact_o);

    // R3
    pos_dir_neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == RM_TO_POS && sign_i) |=> (exp_o == $past(exp_i)));

    // R4
    neg_dir_pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == RM_TO_NEG && !sign_i) |=> (exp_o == $past(exp_i)));

endmodule

// File: tb/fp_round_unit_tb.sv
module fp_round_unit_tb_top;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam logic [FRAC_W-1:0] ONES = {FRAC_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sign_i = 1'b0;
    logic [EXP_W-1:0]  exp_i = '0;
    logic [FRAC_W:0]   sig_i = '0;
    logic              rnd_i = 1'b0;
    logic              stk_i = 1'b0;
    logic [1:0]        mode_i = 2'b00;
    logic [FRAC_W-1:0] frac_o;
    logic [EXP_W-1:0]  exp_o;
    logic              inexact_o;
    logic              ovf_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fp_round_unit #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i),
        .sig_i(sig_i), .rnd_i(rnd_i), .stk_i(stk_i), .mode_i(mode_i),
        .frac_o(frac_o), .exp_o(exp_o), .inexact_o(inexact_o), .ovf_o(ovf_o)
    );

    localparam int RES_W = FRAC_W + EXP_W + 2;

    function automatic logic [RES_W-1:0] model(input logic s, input logic [EXP_W-1:0] e,
                                                input logic [FRAC_W-1:0] f, input logic r,
                                                input logic k, input logic [1:0] m);
        logic up;
        logic [FRAC_W-1:0] nf;
        logic [EXP_W-1:0] ne;
        logic ov;
        case (m)
            2'b00: up = r && (k || f[0]);
            2'b01: up = 1'b0;
            2'b10: up = (r || k) && !s;
            default: up = (r || k) && s;
        endcase
        nf = f; ne = e; ov = 1'b0;
        if (up) begin
            if (f == ONES) begin
                nf = '0;
                ne = e + 1'b1;
                ov = (e >= 8'd254);
            end else begin
                nf = f + 1'b1;
            end
        end
        return {nf, ne, r || k, ov};
    endfunction

    task automatic check(input string tag, input logic [RES_W-1:0] got, input logic [RES_W-1:0] want);
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", tag, got, want);
        end
    endtask

    task automatic apply(input string tag, input logic s, input logic [EXP_W-1:0] e,
                         input logic [FRAC_W-1:0] f, input logic r, input logic k,
                         input logic [1:0] m, input logic [RES_W-1:0] want);
        @(negedge clk);
        sign_i = s; exp_i = e; sig_i = {1'b1, f}; rnd_i = r; stk_i = k; mode_i = m;
        @(negedge clk);
        check(tag, {frac_o, exp_o, inexact_o, ovf_o}, want);
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00: return "R1/R2 random";
            2'b01: return "R5 random";
            2'b10: return "R3 random";
            default: return "R4 random";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [FRAC_W-1:0] base;
        void'($urandom(32'd1234));
        base = 23'h12_3456;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset", {frac_o, exp_o, inexact_o, ovf_o}, '0);
        rst_n = 1'b1;

        // R1
        apply("R1 rs01", 0, 8'd100, base | 23'd1, 0, 1, 2'b00, {base | 23'd1, 8'd100, 1'b1, 1'b0});
        apply("R1 rs11", 0, 8'd100, base, 1, 1, 2'b00, {base + 23'd1, 8'd100, 1'b1, 1'b0});
        apply("R1 rs00", 1, 8'd100, base, 0, 0, 2'b00, {base, 8'd100, 1'b0, 1'b0});
        // R2
        apply("R2 tie even", 0, 8'd90, 23'h000010, 1, 0, 2'b00, {23'h000010, 8'd90, 1'b1, 1'b0});
        apply("R2 tie odd", 0, 8'd90, 23'h000011, 1, 0, 2'b00, {23'h000012, 8'd90, 1'b1, 1'b0});
        // R3
        apply("R3 pos", 0, 8'd50, base, 1, 0, 2'b10, {base + 23'd1, 8'd50, 1'b1, 1'b0});
        apply("R3 neg", 1, 8'd50, base, 1, 1, 2'b10, {base, 8'd50, 1'b1, 1'b0});
        // R4
        apply("R4 neg", 1, 8'd50, base, 0, 1, 2'b11, {base + 23'd1, 8'd50, 1'b1, 1'b0});
        apply("R4 pos", 0, 8'd50, base, 1, 1, 2'b11, {base, 8'd50, 1'b1, 1'b0});
        // R5
        apply("R5 trunc", 0, 8'd77, ONES, 1, 1, 2'b01, {ONES, 8'd77, 1'b1, 1'b0});
        // R6
        apply("R6 carry", 1, 8'd100, ONES, 1, 1, 2'b00, {23'd0, 8'd101, 1'b1, 1'b0});
        // R7
        apply("R7 inexact rz", 0, 8'd10, base, 0, 1, 2'b01, {base, 8'd10, 1'b1, 1'b0});
        // R8
        apply("R8 edge", 0, 8'd254, ONES, 1, 0, 2'b10, {23'd0, 8'd255, 1'b1, 1'b1});
        apply("R8 below", 0, 8'd253, ONES, 1, 0, 2'b10, {23'd0, 8'd254, 1'b1, 1'b0});
        apply("R8 no carry", 0, 8'd254, base, 1, 1, 2'b00, {base + 23'd1, 8'd254, 1'b1, 1'b0});

        for (int i = 0; i < 400; i++) begin
            logic s, r, k;
            logic [EXP_W-1:0] e;
            logic [FRAC_W-1:0] f;
            logic [1:0] m;
            s = 1'($urandom);
            r = 1'($urandom);
            k = 1'($urandom);
            m = 2'($urandom);
            e = ($urandom % 4 == 0) ? 8'd254 : 8'(1 + $urandom % 254);
            case ($urandom % 4)
                0: f = ONES;
                1: f = ONES - 23'(($urandom % 2));
                default: f = 23'($urandom);
            endcase
            apply(mode_tag(m), s, e, f, r, k, m, model(s, e, f, r, k, m));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule